// File: doc/BRIEF.md
# Paced DAC Code Register with Double Buffering

This block holds the digital code driven to a digital-to-analog converter and paces how that code is updated. A reload down-counter advances once per prescaled tick. Each time it expires, it raises a request flag, which can be forwarded to a DMA engine so that the engine supplies the next sample. Software or the DMA engine writes new samples through a small register bus. When the pacing counter and double buffering are both switched on, a written sample waits in a hidden staging register. It moves to the converter only at the next counter expiry, so the output changes at exact tick-aligned moments whatever the bus latency.

The bus has three registers: the active code, a control word and the reload value. The running count is internal and cannot be reached from the bus. The converter itself, the prescaler, the DMA controller and any interrupt logic sit outside the block.

Top module: `dac_pacer`

## Requirements
- R1: The counter runs only while the count-enable control bit is 1, and it changes only on a cycle with `tick` high. The first tick after the counter is enabled loads the reload value. Each later tick decrements the count. A tick that finds the count at zero is an expiry, so a reload value N gives one expiry every N+1 ticks.
- R2: An expiry reloads the counter from the reload register and sets the request flag.
- R3: Any bus write to the data register clears the request flag. If that write falls in the same cycle as an expiry, the flag ends up set.
- R4: `dma_req` is high exactly when the request flag is set and the DMA-enable control bit is 1. Both bits reset to 0.
- R5: Staged mode is active only when both count-enable and double-buffer-enable are 1. In staged mode, a data write changes only the staging register and leaves `dac_code` unchanged. The staging register is transferred to `dac_code` at each expiry.
- R6: Outside staged mode, a data write updates `dac_code` at the same clock edge. An expiry outside staged mode leaves `dac_code` unchanged.
- R7: A bus read of the data register returns the active code, zero-extended, and never the staging register.
- R8: Control word layout: bit 0 is the request flag (read-only; a bus write to it has no effect), bit 1 is double-buffer enable, bit 2 is count enable, bit 3 is DMA enable. The other bits read 0. All four bits reset to 0.
- R9: A write to the reload register does not disturb the running count. The new value is first used at the next reload. The reload register reads back what was written, and it resets to 0.
- R10: When a staged-mode data write and an expiry fall in the same cycle, `dac_code` takes the staging value from before that write, and the written value stays staged for the following expiry.
- R11: With a reload value of 0, every tick after the loading tick is an expiry.
- R12: Register addresses on `bus_addr`: 0 is data, 1 is control, 2 is reload, and address 3 reads 0. Writes occur on cycles with `bus_wr` high. `bus_rdata` follows `bus_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable, one cycle per count step |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| dac_code | output | CODE_W | Active converter code |
| dma_req | output | 1 | Gated request to the DMA engine |

## Verification
The hazard is a data write that lands in the same cycle as a counter expiry. In that cycle the flag clear competes with the flag set, and the write into the staging register competes with the transfer out of it. The bench counts ticks from a known reload value so that a staged-mode write arrives on the exact expiry tick. It then confirms three things: `dma_req` stays high, the converter receives the sample staged before that write, and the new sample appears only at the next expiry. A scoreboard queue holds every expected change of `dac_code`, so an extra, missing or early update is reported.

// File: rtl/dac_pacer_pkg.sv
package dac_pacer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd2;

  localparam int BIT_FLAG = 0;
  localparam int BIT_DBUF = 1;
  localparam int BIT_CNT  = 2;
  localparam int BIT_DMA  = 3;

  typedef struct packed {
    logic dma_en;
    logic cnt_en;
    logic dbuf_en;
  } ctrl_t;
endpackage

// File: rtl/dac_pacer_timer.sv
module dac_pacer_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] reload,
  output logic             timeout
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             armed_q, armed_d;

  always_comb begin
    count_d = count_q;
    armed_d = armed_q;
    timeout = 1'b0;
    if (!cnt_en) begin
      armed_d = 1'b0;
    end else if (tick) begin
      if (!armed_q) begin
        count_d = reload;
        armed_d = 1'b1;
      end else if (count_q == '0) begin
        count_d = reload;
        timeout = 1'b1;
      end else begin
        count_d = count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else begin
      count_q <= count_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/dac_pacer_buffer.sv
module dac_pacer_buffer #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic [CODE_W-1:0] wdata,
  input  logic              staged,
  input  logic              timeout,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] stage_q, stage_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    stage_d = data_we ? wdata : stage_q;
    code_d  = code_q;
    if (staged) begin
      if (timeout) code_d = stage_q;
    end else if (data_we) begin
      code_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      code_q  <= '0;
    end else begin
      stage_q <= stage_d;
      code_q  <= code_d;
    end
  end

  assign code = code_q;
endmodule

// File: rtl/dac_pacer_regs.sv
module dac_pacer_regs
  import dac_pacer_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CNT_W  = 16,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              timeout,
  input  logic [CODE_W-1:0] code,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic [CNT_W-1:0]  reload,
  output logic [BUS_W-1:0]  bus_rdata
);
  ctrl_t            ctrl_q, ctrl_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             wr_data, wr_ctrl, wr_reload;
  logic             unused_hi;

  assign unused_hi = ^bus_wdata[BUS_W-1:CNT_W];
  assign wr_data   = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_reload = bus_wr && (bus_addr == ADDR_RELOAD);

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    flag_d   = flag_q;
    if (wr_ctrl) begin
      ctrl_d.dbuf_en = bus_wdata[BIT_DBUF];
      ctrl_d.cnt_en  = bus_wdata[BIT_CNT];
      ctrl_d.dma_en  = bus_wdata[BIT_DMA];
    end
    if (wr_reload) reload_d = bus_wdata[CNT_W-1:0];
    if (timeout)      flag_d = 1'b1;
    else if (wr_data) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
      reload_q <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      flag_q   <= flag_d;
      reload_q <= reload_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_DATA:   bus_rdata[CODE_W-1:0] = code;
      ADDR_CTRL: begin
        bus_rdata[BIT_FLAG] = flag_q;
        bus_rdata[BIT_DBUF] = ctrl_q.dbuf_en;
        bus_rdata[BIT_CNT]  = ctrl_q.cnt_en;
        bus_rdata[BIT_DMA]  = ctrl_q.dma_en;
      end
      ADDR_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
      default:     bus_rdata = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign flag   = flag_q;
  assign reload = reload_q;
endmodule

// File: rtl/dac_pacer.sv
module dac_pacer
  import dac_pacer_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CNT_W  = 16,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [CODE_W-1:0] dac_code,
  output logic              dma_req
);
  ctrl_t            ctrl;
  logic             flag;
  logic [CNT_W-1:0] reload;
  logic             timeout;
  logic             staged;
  logic             data_we;

  assign data_we = bus_wr && (bus_addr == ADDR_DATA);
  assign staged  = ctrl.dbuf_en && ctrl.cnt_en;
  assign dma_req = flag && ctrl.dma_en;

  dac_pacer_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .timeout   (timeout),
    .code      (dac_code),
    .ctrl      (ctrl),
    .flag      (flag),
    .reload    (reload),
    .bus_rdata (bus_rdata)
  );

  dac_pacer_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt_en  (ctrl.cnt_en),
    .reload  (reload),
    .timeout (timeout)
  );

  dac_pacer_buffer #(.CODE_W(CODE_W)) u_buffer (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_we (data_we),
    .wdata   (bus_wdata[CODE_W-1:0]),
    .staged  (staged),
    .timeout (timeout),
    .code    (dac_code)
  );
endmodule

// File: rtl/dac_pacer_chk.sv
module dac_pacer_chk #(
  parameter int BUS_W  = 32,
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [CODE_W-1:0] dac_code,
  input logic              dma_req,
  input logic              timeout,
  input logic              staged,
  input logic              flag,
  input logic              cnt_en,
  input logic              dma_en
);
  logic data_wr;
  assign data_wr = bus_wr && (bus_addr == 2'd0);

  AST_EXPIRY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (tick && cnt_en)); // R1

  AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> flag); // R2

  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !timeout) |=> !flag); // R3

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req); // R4

  AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (staged && !timeout) |=> $stable(dac_code)); // R5

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !staged) |=> (dac_code == $past(bus_wdata[CODE_W-1:0]))); // R6
endmodule

bind dac_pacer dac_pacer_chk #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .dac_code  (dac_code),
  .dma_req   (dma_req),
  .timeout   (timeout),
  .staged    (staged),
  .flag      (flag),
  .cnt_en    (ctrl.cnt_en),
  .dma_en    (ctrl.dma_en)
);

// File: tb/dac_pacer_test.sv
module dac_pacer_test;
  localparam int CODE_W = 10;
  localparam int BUS_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              bus_wr = 1'b0;
  logic [1:0]        bus_addr = 2'd0;
  logic [BUS_W-1:0]  bus_wdata = '0;
  logic [BUS_W-1:0]  bus_rdata;
  logic [CODE_W-1:0] dac_code;
  logic              dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [CODE_W-1:0] val;
    string             req;
  } exp_t;
  exp_t sb_q[$];
  logic [CODE_W-1:0] prev_code;

  always #2 clk = ~clk;

  dac_pacer #(.BUS_W(BUS_W), .CODE_W(CODE_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dac_code(dac_code), .dma_req(dma_req)
  );

  // Monitor: every change of dac_code must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && (dac_code !== prev_code)) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R5/R6 unexpected code change: actual %h expected no change", dac_code);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (dac_code !== e.val) begin
          errors++;
          $display("FAIL %s code: actual %h expected %h", e.req, dac_code, e.val);
        end
      end
    end
    prev_code = dac_code;
  end

  task automatic push(input logic [CODE_W-1:0] v, input string req);
    exp_t e;
    e.val = v;
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [BUS_W-1:0] d, input logic t);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = t;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 1'b0; tick = 1'b1;
    end
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [BUS_W-1:0] exp, input string req);
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0; bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d: actual %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_req(input logic exp, input string req);
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    #1;
    checks++;
    if (dma_req !== exp) begin
      errors++;
      $display("FAIL %s dma_req: actual %b expected %b", req, dma_req, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    prev_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // Reset state (R8, R9, R4)
    chk_rd(2'd1, 32'h0, "R8");
    chk_rd(2'd0, 32'h0, "R7");
    chk_rd(2'd2, 32'h0, "R9");
    chk_req(1'b0, "R4");

    // Direct write (R6, R7)
    push(10'h155, "R6"); wr(2'd0, 32'h155, 1'b0);
    chk_rd(2'd0, 32'h155, "R7");

    // Reload 3, enable counter and DMA; flag bit write ignored (R8)
    wr(2'd2, 32'd3, 1'b0);
    wr(2'd1, 32'hD, 1'b0);
    chk_rd(2'd1, 32'hC, "R8");

    // First tick loads, expiry on 5th tick (R1, R2)
    ticks(4); chk_req(1'b0, "R1");
    ticks(1); chk_req(1'b1, "R2");
    push(10'h0C3, "R6"); wr(2'd0, 32'h0C3, 1'b0);
    chk_req(1'b0, "R3");

    // DMA gating (R4), flag visible in control (R8)
    wr(2'd1, 32'h4, 1'b0);
    ticks(3); chk_rd(2'd1, 32'h4, "R1");
    ticks(1); chk_req(1'b0, "R4");
    chk_rd(2'd1, 32'h5, "R8");
    wr(2'd1, 32'hC, 1'b0); chk_req(1'b1, "R4");

    // Reload change takes effect at next reload (R9)
    wr(2'd2, 32'd1, 1'b0);
    push(10'h101, "R6"); wr(2'd0, 32'h101, 1'b0);
    chk_req(1'b0, "R3");
    ticks(3); chk_req(1'b0, "R9");
    ticks(1); chk_req(1'b1, "R9");
    push(10'h102, "R6"); wr(2'd0, 32'h102, 1'b0);
    ticks(1); chk_req(1'b0, "R9");
    ticks(1); chk_req(1'b1, "R9");
    chk_rd(2'd2, 32'd1, "R9");

    // Staged mode (R5, R7)
    wr(2'd1, 32'hE, 1'b0);
    wr(2'd0, 32'h0AA, 1'b0);
    chk_req(1'b0, "R3");
    chk_rd(2'd0, 32'h102, "R7");
    ticks(1); chk_rd(2'd0, 32'h102, "R5");
    push(10'h0AA, "R5"); ticks(1);
    chk_req(1'b1, "R2");
    chk_rd(2'd0, 32'h0AA, "R5");

    // Write coinciding with expiry (R10, R3)
    wr(2'd0, 32'h0F0, 1'b1);
    chk_req(1'b0, "R3");
    push(10'h0F0, "R10"); wr(2'd0, 32'h333, 1'b1);
    chk_req(1'b1, "R3");
    chk_rd(2'd0, 32'h0F0, "R10");
    ticks(1);
    push(10'h333, "R10"); ticks(1);
    chk_rd(2'd0, 32'h333, "R10");

    // Double-buffer without count enable is direct (R5)
    wr(2'd1, 32'hA, 1'b0);
    push(10'h2A5, "R5"); wr(2'd0, 32'h2A5, 1'b0);
    chk_rd(2'd0, 32'h2A5, "R5");
    chk_req(1'b0, "R3");
    ticks(4); chk_req(1'b0, "R1");

    // Reload zero expires every tick (R11)
    wr(2'd2, 32'd0, 1'b0);
    wr(2'd1, 32'hC, 1'b0);
    ticks(1); chk_req(1'b0, "R11");
    ticks(1); chk_req(1'b1, "R11");
    push(10'h011, "R6"); wr(2'd0, 32'h011, 1'b0);
    chk_req(1'b0, "R3");
    ticks(1); chk_req(1'b1, "R11");

    // Unused address (R12)
    chk_rd(2'd3, 32'h0, "R12");

    repeat (2) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending code updates: actual %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule